// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block produces one pulse-width-modulated output from a free-running counter that ramps up and then down. The counter advances by one step on each cycle where the timer tick is high. It climbs from zero to a ceiling set by the selected resolution, then falls back to zero, and repeats. Because the waveform is symmetric about the turning points, every pulse is centred on the same instant of each period, whatever its width.

The pin changes when the count equals a compare value. The direction of travel at that match decides whether the pin goes high or low, and a mode field chooses the polarity or detaches the pin. The host writes new compare values through a small register port at any time. Each value waits in a holding register and becomes active only on the step that leaves the ceiling, so a write that arrives mid-period cannot produce a runt pulse. A new resolution is held back in the same way until the count next lands on zero.

Top module: `pwm_pc_timer`

## Requirements
- R1: While and just after reset the count is 0, the pin and its enable are 0, the ceiling pulse is 0, the compare value is 0, resolution code is 0 and the mode is 00.
- R2: The count moves by exactly one on a cycle where `tick_i` is high and holds its value on every cycle where `tick_i` is low.
- R3: The count rises from 0 to the ceiling and falls back to 0 without stopping. The ceiling and zero each last one tick, so one period is twice the ceiling in ticks.
- R4: The resolution code sits in config bits [3:2]. Code 0 gives a ceiling of 255, code 1 gives 511, and codes 2 and 3 give 1023. A new code takes effect when the count next arrives at 0 while falling.
- R5: `top_o` is high exactly on cycles where `tick_i` is high and the count equals the active ceiling.
- R6: A compare write (`wr_sel_i`=0) stores `wr_data_i[9:0]` in a holding register. The active compare value loads from it on the tick that leaves the ceiling, and no other write changes the active value.
- R7: The match tests the next count against the active compare value masked to the low 8, 9 or 10 bits of the active resolution.
- R8: The mode sits in config bits [1:0] (`wr_sel_i`=1). Modes 00 and 01 drive `pwm_oe_o` low. Modes 10 and 11 drive it high, and the new mode applies from the cycle after the write.
- R9: In mode 10, a match reached while rising clears the pin and a match reached while falling sets it. The pin changes in the same cycle the count takes the matching value. Arriving at the ceiling counts as rising, and arriving at 0 from above counts as falling.
- R10: In mode 11, a match reached while rising sets the pin and a match reached while falling clears it, with the same timing as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer step enable (prescaled tick) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: compare value, 1: config (mode, resolution) |
| wr_data_i | input | 10 | Write data |
| pwm_o | output | 1 | PWM pin level |
| pwm_oe_o | output | 1 | Pin enable, high when the mode connects the pin |
| count_o | output | 10 | Current count |
| top_o | output | 1 | One-tick pulse when the count is at the ceiling |

## Verification
A scoreboard model predicts count, pin, enable and ceiling pulse every cycle, and the block is compared against it under several stimulus patterns:
- **Continuous tick at each resolution.** Separates a correct ceiling and period from off-by-one turning points.
- **Gapped tick.** Shows whether the block holds still between enables.
- **Mid-period compare writes.** Expose an active value that updates early instead of at the ceiling.
- **Compare values with bits above the resolution set.** Show whether the mask is applied.
- **Both polarities and the two detached modes.** Separate the set/clear sense and the enable decode.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF_A  = 2'b00,
    MODE_OFF_B  = 2'b01,
    MODE_NONINV = 2'b10,
    MODE_INV    = 2'b11
  } pwm_mode_e;

  // counter width in bits for a resolution code; codes past the last saturate
  function automatic int unsigned res_width(int unsigned min_res, int unsigned num_res,
                                            int unsigned code);
    return min_res + ((code >= num_res) ? (num_res - 1) : code);
  endfunction

endpackage

// File: rtl/pwm_pc_counter.sv
module pwm_pc_counter
  import pwm_pc_pkg::*;
#(
  parameter int unsigned MIN_RES = 8,
  parameter int unsigned NUM_RES = 3,
  parameter int unsigned CNT_W   = MIN_RES + NUM_RES - 1,
  parameter int unsigned RES_CW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RES_CW-1:0] res_req_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  nxt_o,
  output logic [CNT_W-1:0]  top_val_o,
  output logic              at_top_o,
  output logic              step_up_o
);

  logic [RES_CW-1:0] res_act_q;
  logic [CNT_W-1:0]  cnt_q, nxt, top_val;
  logic              up_q, step_up, at_top, at_zero;
  int unsigned       width;

  always_comb begin
    width   = res_width(MIN_RES, NUM_RES, 32'(res_act_q));
    top_val = '0;
    for (int unsigned i = 0; i < CNT_W; i++) begin
      if (i < width) top_val[i] = 1'b1;
    end
  end

  assign at_top  = (cnt_q == top_val);
  assign at_zero = (cnt_q == '0);
  // up_q is the direction of the last step taken
  assign step_up = up_q ? !at_top : at_zero;
  assign nxt     = step_up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      up_q      <= 1'b1;
      res_act_q <= '0;
    end else if (tick_i) begin
      cnt_q <= nxt;
      up_q  <= step_up;
      if (nxt == '0) res_act_q <= res_req_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign nxt_o     = nxt;
  assign top_val_o = top_val;
  assign at_top_o  = at_top;
  assign step_up_o = step_up;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_val); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)) ||
                cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)))); // R2
  AST_TURN_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && at_top) |=> cnt_q == CNT_W'($past(top_val) - CNT_W'(1))); // R3
  AST_RES_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_act_q) |-> cnt_q == '0); // R4

endmodule

// File: rtl/pwm_pc_compare.sv
module pwm_pc_compare #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic             match_o
);

  logic [CNT_W-1:0] hold_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i)   hold_q <= data_i;
      if (load_i) act_q  <= hold_q;
    end
  end

  assign match_o = tick_i && (nxt_i == (act_q & mask_i));

  AST_ACT_ONLY_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q)); // R6

endmodule

// File: rtl/pwm_pc_pin.sv
module pwm_pc_pin
  import pwm_pc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwm_mode_e mode_i,
  input  logic      match_i,
  input  logic      up_i,
  output logic      pwm_o,
  output logic      oe_o
);

  logic pwm_q;
  logic connected, level;

  assign connected = mode_i[1];
  assign level     = mode_i[0] ? up_i : !up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pwm_q <= 1'b0;
    else if (match_i && connected)  pwm_q <= level;
  end

  assign pwm_o = pwm_q;
  assign oe_o  = connected;

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> $stable(pwm_q)); // R9
  AST_NONINV_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == MODE_NONINV) |=> pwm_q == !$past(up_i)); // R9
  AST_INV_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == MODE_INV) |=> pwm_q == $past(up_i)); // R10

endmodule

// File: rtl/pwm_pc_timer.sv
module pwm_pc_timer
  import pwm_pc_pkg::*;
#(
  parameter int unsigned MIN_RES = 8,
  parameter int unsigned NUM_RES = 3,
  localparam int unsigned CNT_W  = MIN_RES + NUM_RES - 1,
  localparam int unsigned RES_CW = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             pwm_oe_o,
  output logic [CNT_W-1:0] count_o,
  output logic             top_o
);

  pwm_mode_e         mode_q;
  logic [RES_CW-1:0] res_q;
  logic [CNT_W-1:0]  cnt, nxt, top_val;
  logic              at_top, step_up, match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF_A;
      res_q  <= '0;
    end else if (wr_en_i && wr_sel_i) begin
      mode_q <= pwm_mode_e'(wr_data_i[1:0]);
      res_q  <= wr_data_i[2 +: RES_CW];
    end
  end

  pwm_pc_counter #(
    .MIN_RES(MIN_RES), .NUM_RES(NUM_RES), .CNT_W(CNT_W), .RES_CW(RES_CW)
  ) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .res_req_i (res_q),
    .cnt_o     (cnt),
    .nxt_o     (nxt),
    .top_val_o (top_val),
    .at_top_o  (at_top),
    .step_up_o (step_up)
  );

  pwm_pc_compare #(.CNT_W(CNT_W)) u_compare (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_i    (wr_en_i && !wr_sel_i),
    .data_i  (wr_data_i),
    .load_i  (tick_i && at_top),
    .mask_i  (top_val),
    .nxt_i   (nxt),
    .match_o (match)
  );

  pwm_pc_pin u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q),
    .match_i (match),
    .up_i    (step_up),
    .pwm_o   (pwm_o),
    .oe_o    (pwm_oe_o)
  );

  assign count_o = cnt;
  assign top_o   = tick_i && at_top;

  AST_TOP_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_o |=> !top_o); // R5
  AST_TOP_AT_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_o |=> count_o != '0); // R3

endmodule

// File: tb/tb_pwm_pc_timer.sv
`timescale 1ns/1ps
module tb_pwm_pc_timer;

  logic       clk, rst_n, tick, wr_en, wr_sel;
  logic [9:0] wr_data;
  logic       pwm, pwm_oe, top;
  logic [9:0] count;

  pwm_pc_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .pwm_o(pwm), .pwm_oe_o(pwm_oe), .count_o(count), .top_o(top)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int cnt;
    bit pwm;
    bit oe;
    int ceil;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  // ceiling per resolution code, per R4
  function automatic int ceil_of(int code);
    case (code)
      0:       return 255;
      1:       return 511;
      default: return 1023;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // reference model: advances on each edge from the inputs driven before it
  int m_cnt, m_cmp_buf, m_cmp_act, m_res_act, m_res_buf, m_mode, m_nx, m_top;
  bit m_up, m_pwm, m_su;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_pwm = 0; m_cmp_buf = 0; m_cmp_act = 0;
      m_res_act = 0; m_res_buf = 0; m_mode = 0;
    end else begin
      m_top = ceil_of(m_res_act);
      if (tick) begin
        m_su = m_up ? (m_cnt != m_top) : (m_cnt == 0);
        m_nx = m_su ? m_cnt + 1 : m_cnt - 1;
        if (m_nx == (m_cmp_act & m_top) && m_mode[1]) m_pwm = m_mode[0] ? m_su : !m_su;
        if (m_cnt == m_top) m_cmp_act = m_cmp_buf;
        if (m_nx == 0) m_res_act = m_res_buf;
        m_cnt = m_nx;
        m_up  = m_su;
      end
      if (wr_en) begin
        if (!wr_sel) m_cmp_buf = int'(wr_data);
        else begin
          m_mode    = int'(wr_data[1:0]);
          m_res_buf = int'(wr_data[3:2]);
        end
      end
    end
    sb_q.push_back('{cnt: m_cnt, pwm: m_pwm, oe: m_mode[1], ceil: ceil_of(m_res_act)});
  end

  // monitor: compares outputs mid-cycle against the oldest prediction
  always @(negedge clk) begin
    if (sb_q.size() > 0 && !done) begin
      exp_t e;
      e = sb_q.pop_front();
      check(tag, "count", int'(count), e.cnt);
      check("R8", "pwm_oe", int'(pwm_oe), int'(e.oe));
      if (e.oe) check(tag, "pwm", int'(pwm), int'(e.pwm));
      check("R5", "top", int'(top), int'(rst_n && tick && (e.cnt == e.ceil)));
    end
  end

  task automatic wr(input bit sel, input int data);
    @(posedge clk); #1;
    wr_en = 1; wr_sel = sel; wr_data = 10'(data);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic measure(input int exp, input string req);
    int n;
    do @(negedge clk); while (!top);
    n = 0;
    do begin @(negedge clk); n++; end while (!top);
    check(req, "period", n, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 0; tick = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    tag = "R1";
    run(4);
    rst_n = 1;
    @(negedge clk);
    check("R1", "count after reset", int'(count), 0);
    check("R1", "pwm after reset", int'(pwm), 0);
    check("R1", "oe after reset", int'(pwm_oe), 0);
    check("R1", "top after reset", int'(top), 0);

    // non-inverted, 8-bit, continuous tick
    tag = "R9";
    wr(1, 4'b0010);
    wr(0, 100);
    tick = 1;
    measure(510, "R3");
    run(600);

    // gapped tick
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      tick = (i % 3 != 0);
    end
    tick = 1;

    // unsynchronized compare updates
    tag = "R6";
    run(137);
    wr(0, 37);
    run(90);
    wr(0, 200);
    run(1200);

    // compare bits above the resolution
    tag = "R7";
    wr(0, 10'h1FF);
    run(1100);
    wr(0, 10'h305);
    run(1100);

    // inverted polarity
    tag = "R10";
    wr(1, 4'b0011);
    wr(0, 60);
    run(1100);

    // detached modes
    tag = "R8";
    wr(1, 4'b0001);
    run(50);
    @(negedge clk);
    check("R8", "oe in mode 01", int'(pwm_oe), 0);
    wr(1, 4'b0000);
    run(50);
    @(negedge clk);
    check("R8", "oe in mode 00", int'(pwm_oe), 0);

    // resolutions
    tag = "R4";
    wr(1, 4'b0110);
    wr(0, 300);
    run(2100);
    measure(1022, "R4");
    wr(1, 4'b1010);
    wr(0, 700);
    run(2100);
    measure(2046, "R4");
    wr(1, 4'b1110);
    run(4200);
    measure(2046, "R4");
    run(20);

    finish_run();
  end

endmodule